// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller made of several 8-pin ports. Each port has its own register bank, and the banks repeat at a fixed stride of 0x30 bytes. Through these registers, software sets each pin's drive style, its output level, its pull-up and its interrupt behaviour. Software reads back the pin level after it has passed an input synchronizer. The block drives the pad-side output value, output enable and pull enable for every pin, and it raises one interrupt line per port.

Every pin can record either a rising or a falling edge, chosen per pin. It cannot record both edges at once. Recorded edges stay in a per-port event register until software writes a one to clear them. The event register can also be driven from a per-port force register for test. A global control register at address 0x00 holds two writable bits: the clock-request output and the selection of synchronizer depth. Its upper bits are read-only and report a version number and the number of ports.

The bus is a simple 16-bit interface. A write takes effect at the clock edge where the write strobe is high, and read data is combinational from the address.

Top module: `mpgpio_top`

## Requirements
- R1: After reset, every pin is in input mode (output enable low) with its pull-up enabled. All port registers read zero, every interrupt line is low, and clk_req is low.
- R2: The control register at address 0x00 holds writable bit 0, which drives clk_req, and writable bit 1. Bits [8:2] read the constant VERSION and bits [15:9] read NUM_PORTS. Writes to these read-only fields have no effect.
- R3: Port p occupies addresses p*0x30 + offset, with these offsets: 0x04 pin level, 0x08 output data, 0x0C drive mode, 0x10 pull disable, 0x14 events, 0x18 interrupt enable, 0x1C force, 0x20 edge select. Pin n of port p is pad bit 8p+n.
- R4: In the drive-mode register, pin n uses bits [2n+1:2n], with 0 = input, 1 = push-pull, 2 = open-drain and 3 = open-source. Input mode never enables the output. Push-pull always enables it. Open-drain enables it only while the data bit is 0, and open-source only while the data bit is 1. pad_out always follows the data bit.
- R5: A 1 in the pull-disable register turns off that pin's pull-up (pad_pull_en low), and a 0 turns it on.
- R6: With control bit 1 set, a pad change appears in the pin-level register after two clock edges. With control bit 1 clear, it appears after one clock edge.
- R7: An edge-select bit of 1 records rising edges and 0 records falling edges. The opposite edge records nothing. The event bit is set one clock edge after the new level appears in the pin-level register.
- R8: Writing a 1 to an event bit clears it, and writing 0 leaves it unchanged. An edge detected in the same cycle as the clearing write leaves the bit set.
- R9: An event bit is set even while its enable bit is 0. A port's interrupt line is high exactly when some event bit of that port has its enable bit set.
- R10: While a force bit is 1, its event bit is held set (one cycle after the force write) and cannot be cleared. Once the force bit is written to 0, the event can be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 2*PINS | Write data |
| bus_rdata | output | 2*PINS | Combinational read data |
| pad_in | input | NUM_PORTS*PINS | Pad input levels |
| pad_out | output | NUM_PORTS*PINS | Pad output values |
| pad_oe | output | NUM_PORTS*PINS | Pad output enables |
| pad_pull_en | output | NUM_PORTS*PINS | Pad pull-up enables |
| port_irq | output | NUM_PORTS | One interrupt line per port |
| clk_req | output | 1 | Clock request, control bit 0 |

## Verification
The hardest case to reach is an edge arriving in the very cycle that software writes a one to clear the same event bit. The bench selects one-stage synchronization so the latency from pad to event is known to be exactly two edges. It then raises the pad, waits one edge, and places the clearing write in the following cycle, so that detection and clearing meet at one edge. The force register is exercised the same way: a clearing write is issued while forcing is active and again after forcing is released.

// File: rtl/mpgpio_pkg.sv
package mpgpio_pkg;

  typedef enum logic [1:0] {
    DRV_IN = 2'd0,
    DRV_PP = 2'd1,
    DRV_OD = 2'd2,
    DRV_OS = 2'd3
  } drv_mode_e;

  localparam int unsigned BANK_STRIDE = 'h30;
  localparam int unsigned OFS_CTRL    = 'h00;
  localparam int unsigned OFS_LEVEL   = 'h04;
  localparam int unsigned OFS_DATA    = 'h08;
  localparam int unsigned OFS_MODE    = 'h0C;
  localparam int unsigned OFS_PULLDIS = 'h10;
  localparam int unsigned OFS_EVENT   = 'h14;
  localparam int unsigned OFS_IEN     = 'h18;
  localparam int unsigned OFS_FORCE   = 'h1C;
  localparam int unsigned OFS_EDGE    = 'h20;

endpackage

// File: rtl/mpgpio_sync.sv
module mpgpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         two_stage,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d;
      st2_q <= st1_q;
    end
  end

  assign q = two_stage ? st2_q : st1_q;

endmodule

// File: rtl/mpgpio_port.sv
module mpgpio_port
  import mpgpio_pkg::*;
#(
  parameter  int PINS  = 8,
  parameter  int OFS_W = 6,
  localparam int DW    = 2 * PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [DW-1:0]    rdata,
  output logic [PINS-1:0]  pad_out,
  output logic [PINS-1:0]  pad_oe,
  output logic [PINS-1:0]  pad_pull_en,
  output logic             irq
);

  logic [PINS-1:0] data_q, data_d, pdis_q, pdis_d, evt_q, evt_d;
  logic [PINS-1:0] ien_q, ien_d, frc_q, frc_d, edge_q, edge_d, prev_q;
  logic [DW-1:0]   mode_q, mode_d;
  logic [PINS-1:0] hit, clr;
  logic wr_data, wr_mode, wr_pdis, wr_evt, wr_ien, wr_frc, wr_edge;

  // write decode
  always_comb begin
    wr_data = wr_en && (ofs == OFS_W'(OFS_DATA));
    wr_mode = wr_en && (ofs == OFS_W'(OFS_MODE));
    wr_pdis = wr_en && (ofs == OFS_W'(OFS_PULLDIS));
    wr_evt  = wr_en && (ofs == OFS_W'(OFS_EVENT));
    wr_ien  = wr_en && (ofs == OFS_W'(OFS_IEN));
    wr_frc  = wr_en && (ofs == OFS_W'(OFS_FORCE));
    wr_edge = wr_en && (ofs == OFS_W'(OFS_EDGE));
  end

  // edge detection and next state
  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      hit[i] = edge_q[i] ? (pin_in[i] & ~prev_q[i]) : (~pin_in[i] & prev_q[i]);
    end
    clr    = wr_evt ? wdata[PINS-1:0] : '0;
    evt_d  = (evt_q & ~clr) | hit | frc_q;
    data_d = wr_data ? wdata[PINS-1:0] : data_q;
    mode_d = wr_mode ? wdata           : mode_q;
    pdis_d = wr_pdis ? wdata[PINS-1:0] : pdis_q;
    ien_d  = wr_ien  ? wdata[PINS-1:0] : ien_q;
    frc_d  = wr_frc  ? wdata[PINS-1:0] : frc_q;
    edge_d = wr_edge ? wdata[PINS-1:0] : edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mode_q <= '0;
      pdis_q <= '0;
      evt_q  <= '0;
      ien_q  <= '0;
      frc_q  <= '0;
      edge_q <= '0;
      prev_q <= '0;
    end else begin
      data_q <= data_d;
      mode_q <= mode_d;
      pdis_q <= pdis_d;
      evt_q  <= evt_d;
      ien_q  <= ien_d;
      frc_q  <= frc_d;
      edge_q <= edge_d;
      prev_q <= pin_in;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_W'(OFS_LEVEL):   rdata = DW'(pin_in);
      OFS_W'(OFS_DATA):    rdata = DW'(data_q);
      OFS_W'(OFS_MODE):    rdata = mode_q;
      OFS_W'(OFS_PULLDIS): rdata = DW'(pdis_q);
      OFS_W'(OFS_EVENT):   rdata = DW'(evt_q);
      OFS_W'(OFS_IEN):     rdata = DW'(ien_q);
      OFS_W'(OFS_FORCE):   rdata = DW'(frc_q);
      OFS_W'(OFS_EDGE):    rdata = DW'(edge_q);
      default:             rdata = '0;
    endcase
  end

  // pad drive
  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      case (drv_mode_e'(mode_q[2*i +: 2]))
        DRV_PP:  pad_oe[i] = 1'b1;
        DRV_OD:  pad_oe[i] = ~data_q[i];
        DRV_OS:  pad_oe[i] = data_q[i];
        default: pad_oe[i] = 1'b0;
      endcase
    end
  end

  assign pad_out     = data_q;
  assign pad_pull_en = ~pdis_q;
  assign irq         = |(evt_q & ien_q);

endmodule

// File: rtl/mpgpio_top.sv
module mpgpio_top
  import mpgpio_pkg::*;
#(
  parameter  int NUM_PORTS = 3,
  parameter  int PINS      = 8,
  parameter  int ADDR_W    = 9,
  parameter  int VERSION   = 5,
  localparam int NPINS     = NUM_PORTS * PINS,
  localparam int DW        = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pull_en,
  output logic [NUM_PORTS-1:0] port_irq,
  output logic              clk_req
);

  localparam int OFS_W = $clog2(BANK_STRIDE);
  localparam logic [6:0] VER_ID   = 7'(VERSION);
  localparam logic [6:0] CORE_CNT = 7'(NUM_PORTS);

  logic [1:0]       ctrl_q, ctrl_d;
  logic             ctrl_sel;
  logic [NPINS-1:0] pin_s;
  logic [DW-1:0]    ctrl_rd;
  logic [DW-1:0]    port_rd [NUM_PORTS];

  // global control register
  always_comb begin
    ctrl_sel = (bus_addr == ADDR_W'(OFS_CTRL));
    ctrl_d   = (bus_wr && ctrl_sel) ? bus_wdata[1:0] : ctrl_q;
    ctrl_rd  = ctrl_sel ? DW'({CORE_CNT, VER_ID, ctrl_q}) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign clk_req = ctrl_q[0];

  mpgpio_sync #(.W(NPINS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .two_stage (ctrl_q[1]),
    .d         (pad_in),
    .q         (pin_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(p * BANK_STRIDE);
    logic [ADDR_W-1:0] rel;
    logic              sel;
    logic [DW-1:0]     prd;

    assign rel = bus_addr - BASE;
    assign sel = (bus_addr >= BASE) && (rel < ADDR_W'(BANK_STRIDE));

    mpgpio_port #(.PINS(PINS), .OFS_W(OFS_W)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_wr && sel),
      .ofs         (rel[OFS_W-1:0]),
      .wdata       (bus_wdata),
      .pin_in      (pin_s[p*PINS +: PINS]),
      .rdata       (prd),
      .pad_out     (pad_out[p*PINS +: PINS]),
      .pad_oe      (pad_oe[p*PINS +: PINS]),
      .pad_pull_en (pad_pull_en[p*PINS +: PINS]),
      .irq         (port_irq[p])
    );

    assign port_rd[p] = sel ? prd : '0;
  end

  always_comb begin
    bus_rdata = ctrl_rd;
    for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rd[p];
  end

endmodule

module mpgpio_chk #(
  parameter  int NUM_PORTS = 3,
  parameter  int PINS      = 8,
  parameter  int ADDR_W    = 9,
  parameter  int VERSION   = 5,
  localparam int NPINS     = NUM_PORTS * PINS,
  localparam int DW        = 2 * PINS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 wd0,
  input logic [DW-1:3]        rd_hi,
  input logic                 rd0,
  input logic [NPINS-1:0]     pad_out,
  input logic [NPINS-1:0]     pad_oe,
  input logic [NPINS-1:0]     pad_pull_en,
  input logic [NUM_PORTS-1:0] port_irq,
  input logic                 clk_req
);

  localparam logic [DW-1:3] ID_EXP = (DW-3)'({7'(NUM_PORTS), 7'(VERSION)} >> 1);

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> (clk_req == $past(wd0)));  // R2

  AST_CTRL_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (rd_hi == ID_EXP && rd0 == clk_req));  // R2

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_oe));  // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_out));  // R4

  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_pull_en));  // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((port_irq & $past(port_irq)) == $past(port_irq)));  // R9

endmodule

bind mpgpio_top mpgpio_chk #(
  .NUM_PORTS(NUM_PORTS), .PINS(PINS), .ADDR_W(ADDR_W), .VERSION(VERSION)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .wd0         (bus_wdata[0]),
  .rd_hi       (bus_rdata[2*PINS-1:3]),
  .rd0         (bus_rdata[0]),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_pull_en (pad_pull_en),
  .port_irq    (port_irq),
  .clk_req     (clk_req)
);

// File: tb/mpgpio_top_tb.sv
`timescale 1ns/100ps
module mpgpio_top_tb;

  localparam int NP = 3;
  localparam int NPINS = NP * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [8:0]       bus_addr = '0;
  logic [15:0]      bus_wdata = '0;
  logic [15:0]      bus_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out, pad_oe, pad_pull_en;
  logic [NP-1:0]    port_irq;
  logic             clk_req;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mpgpio_top #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .port_irq(port_irq), .clk_req(clk_req)
  );

  function automatic logic [8:0] ra(input int p, input int ofs);
    return 9'(p * 'h30 + ofs);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #0.5 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    rd(a, v);
    chk(v == exp, req, 32'(v), 32'(exp));
  endtask

  task automatic t_reset();
    rd_chk(9'h000, 16'h0614, "R1 ctrl reset");
    chk(pad_oe == '0, "R1 oe", 32'(pad_oe), 0);
    chk(pad_pull_en == '1, "R1 pull", 32'(pad_pull_en), 32'hFFFFFF);
    chk(port_irq == '0 && clk_req == 1'b0, "R1 irq/clk_req", {port_irq, clk_req}, 0);
    rd_chk(ra(1, 'h14), 16'h0, "R1 event");
    rd_chk(ra(2, 'h0C), 16'h0, "R1 mode");
  endtask

  task automatic t_ctrl();
    wr(9'h000, 16'hFFFF);
    rd_chk(9'h000, 16'h0617, "R2 ctrl ro fields");
    chk(clk_req == 1'b1, "R2 clk_req set", clk_req, 1);
    wr(9'h000, 16'h0000);
    chk(clk_req == 1'b0, "R2 clk_req clear", clk_req, 0);
  endtask

  task automatic t_addr();
    wr(ra(2, 'h08), 16'h00A5);
    wr(ra(2, 'h0C), 16'h5555);
    #0.5;
    chk(pad_out[23:16] == 8'hA5, "R3 port2 data", pad_out[23:16], 8'hA5);
    chk(pad_oe[23:16] == 8'hFF, "R3 port2 oe", pad_oe[23:16], 8'hFF);
    chk(pad_oe[15:0] == '0, "R3 other ports untouched", pad_oe[15:0], 0);
    rd_chk(ra(2, 'h08), 16'h00A5, "R3 port2 readback");
  endtask

  task automatic t_drive();
    wr(ra(0, 'h0C), 16'h0039);  // pin0 PP, pin1 OD, pin2 OS, pin3 IN
    wr(ra(0, 'h08), 16'h0000);
    #0.5;
    chk(pad_oe[3:0] == 4'b0011, "R4 oe data=0", pad_oe[3:0], 4'b0011);
    wr(ra(0, 'h08), 16'h000F);
    #0.5;
    chk(pad_oe[3:0] == 4'b0101, "R4 oe data=1", pad_oe[3:0], 4'b0101);
    chk(pad_out[3:0] == 4'hF, "R4 out follows data", pad_out[3:0], 4'hF);
  endtask

  task automatic t_pull();
    wr(ra(0, 'h10), 16'h00F0);
    #0.5;
    chk(pad_pull_en[7:0] == 8'h0F, "R5 pull", pad_pull_en[7:0], 8'h0F);
    rd_chk(ra(0, 'h10), 16'h00F0, "R5 readback");
  endtask

  task automatic t_sync();
    logic [15:0] v;
    wr(9'h000, 16'h0002);
    @(negedge clk) pad_in[8] = 1'b1;
    @(posedge clk); rd(ra(1, 'h04), v);
    chk(v[0] == 1'b0, "R6 two-stage after 1 edge", v[0], 0);
    @(posedge clk); rd(ra(1, 'h04), v);
    chk(v[0] == 1'b1, "R6 two-stage after 2 edges", v[0], 1);
    wr(9'h000, 16'h0000);
    @(negedge clk) pad_in[8] = 1'b0;
    rd(ra(1, 'h04), v);
    chk(v[0] == 1'b1, "R6 one-stage before edge", v[0], 1);
    @(posedge clk); rd(ra(1, 'h04), v);
    chk(v[0] == 1'b0, "R6 one-stage after 1 edge", v[0], 0);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    wr(ra(0, 'h20), 16'h0010);  // pin4 rising, pin5 falling
    @(negedge clk) pad_in[5:4] = 2'b11;
    @(posedge clk); rd(ra(0, 'h14), v);
    chk(v == 16'h0, "R7 not yet set", v, 0);
    @(posedge clk); rd(ra(0, 'h14), v);
    chk(v == 16'h0010, "R7 rising only", v, 16'h0010);
    @(negedge clk) pad_in[5:4] = 2'b00;
    @(posedge clk); @(posedge clk);
    rd_chk(ra(0, 'h14), 16'h0030, "R7 falling on pin5");
  endtask

  task automatic t_w1c();
    wr(ra(0, 'h14), 16'h0000);
    rd_chk(ra(0, 'h14), 16'h0030, "R8 write zero no effect");
    wr(ra(0, 'h14), 16'h0010);
    rd_chk(ra(0, 'h14), 16'h0020, "R8 clear one bit");
    @(negedge clk) pad_in[4] = 1'b1;
    @(posedge clk);
    wr(ra(0, 'h14), 16'h0010);  // collides with detection of the new edge
    rd_chk(ra(0, 'h14), 16'h0030, "R8 set wins over clear");
    wr(ra(0, 'h14), 16'h0030);
    rd_chk(ra(0, 'h14), 16'h0000, "R8 clear all");
  endtask

  task automatic t_irq();
    @(negedge clk) pad_in[4] = 1'b0;
    @(posedge clk); @(posedge clk);
    rd_chk(ra(0, 'h14), 16'h0000, "R7 falling ignored on rising pin");
    @(negedge clk) pad_in[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd_chk(ra(0, 'h14), 16'h0010, "R9 event while disabled");
    chk(port_irq == '0, "R9 irq masked", port_irq, 0);
    wr(ra(0, 'h18), 16'h0010);
    #0.5 chk(port_irq == 3'b001, "R9 irq enabled", port_irq, 3'b001);
    wr(ra(0, 'h18), 16'h0020);
    #0.5 chk(port_irq == '0, "R9 other enable", port_irq, 0);
    wr(ra(0, 'h18), 16'h0010);
    wr(ra(0, 'h14), 16'h0010);
    #0.5 chk(port_irq == '0, "R9 irq drops on clear", port_irq, 0);
  endtask

  task automatic t_force();
    wr(ra(2, 'h1C), 16'h0081);
    @(posedge clk);
    rd_chk(ra(2, 'h14), 16'h0081, "R10 forced events");
    wr(ra(2, 'h14), 16'h0081);
    rd_chk(ra(2, 'h14), 16'h0081, "R10 clear blocked while forced");
    wr(ra(2, 'h1C), 16'h0000);
    wr(ra(2, 'h14), 16'h0081);
    rd_chk(ra(2, 'h14), 16'h0000, "R10 cleared after release");
  endtask

  initial begin
    #(200000 * 4);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_addr();
    t_drive();
    t_pull();
    t_sync();
    t_edge();
    t_w1c();
    t_irq();
    t_force();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule